// File: doc/BRIEF.md
# Descriptor-Table Multi-Channel DMA Engine

This block moves data between two memory locations on behalf of several independent channels. Software sets aside a table in memory on a 512-byte boundary. Each channel owns one 16-byte slot in that table. The slot's second word holds the last source address and its third word holds the last destination address. The first and fourth words are not read. Software also sets a per-channel transfer configuration: item width, whether each side advances, the item count written as N-1, and whether completion raises a flag. It then enables the channel and triggers it. The engine reads the two end addresses through its memory master port. It then copies the items one at a time, each as a read followed by a write.

Each incrementing side starts at its end address minus (items left after this one × item width), so the first item lands on the start address. A side that does not advance always uses its end address. When the channel's request pacing is on, a peripheral request input must be seen before each item moves. Channel control uses write-1 bitmaps: set and clear for enable and interrupt enable, trigger, abort, and write-1-to-clear completion and error flags. A single interrupt line ORs the enabled flags. The channel with the lowest number wins arbitration, and each turn serves one item.

Memory data is right-justified on both data buses. `mem_size` encodes 0 = byte, 1 = halfword, 2 = word.

Top module: `dma_engine`

## Requirements
- R1: After reset the enable, interrupt-enable, busy, completion-flag and error-flag bitmaps all read 0, `mem_req` is low and `irq` is low.
- R2: Writing 1s to the enable-set register (0x0C) or enable-clear register (0x10) sets or clears those bits of the enable bitmap (read at 0x08). Zero bits leave it unchanged. Interrupt enable works the same way, with set at 0x18, clear at 0x1C and read at 0x14.
- R3: The table base register (0x04) keeps only address bits 31:9 and reads 0 in bits 8:0. Channel n fetches its source end from base+16n+4 and its destination end from base+16n+8.
- R4: The count field (bits 25:16 of the transfer-config register at 0x100+16n+4) holds items minus one, so 0 moves exactly one item.
- R5: The width field (bits 3:2: 0=8, 1=16, 2=32 bit) sets `mem_size` and masks the data. Source increment (bit 4) and destination increment (bit 5) each step the address by one width per item, with the first item at the end address minus (N-1)×width. A non-incrementing side uses the end address for every item.
- R6: A trigger write (0x20) starts channel n only if it is enabled and its valid bit (bit 0 of transfer config) is set. Otherwise busy stays 0 and nothing moves.
- R7: With request pacing on (bit 0 of the channel config at 0x100+16n), each item waits for that channel's `dreq` bit. A one-cycle pulse releases exactly one item. The descriptor fetch does not wait.
- R8: Busy (0x24) reads 1 from the trigger until the last item is written. On completion with bit 1 of transfer config set, the channel's completion flag (0x28) sets. Writing 1 to that flag clears it.
- R9: Writing 1 to a channel's abort bit (0x30) clears its busy bit. Requests for that channel then move nothing, and no completion flag is raised.
- R10: When several channels are ready, the lowest-numbered one is served. A lower channel that stays ready finishes all its items before a higher one starts.
- R11: An error response to any memory access of a channel sets its error flag (0x2C, write 1 to clear), clears busy and performs no write for that item.
- R12: `irq` is high exactly while some channel has its completion or error flag set together with its interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW (12) | Register byte address |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Register read data (combinational from `reg_addr`) |
| dreq | input | NCH (4) | Per-channel peripheral request |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW (32) | Byte address of the access |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_wdata | output | DW (32) | Write data, right-justified |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | DW (32) | Read data, right-justified, valid with `mem_ack` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a channel parked between items. Its descriptor is already loaded and its busy bit is set, but it waits on a request that never comes. Pacing and abort are only meaningful there. The bench enables pacing and holds `dreq` low long enough for the fetch to finish. It then issues either single-cycle request pulses, counting the writes after each, or an abort followed by further pulses that must move nothing. Bus errors are reached by making the memory model return an error for one chosen source address.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_FSRC = 3'd1,
        S_FDST = 3'd2,
        S_RD   = 3'd3,
        S_WR   = 3'd4
    } dma_st_e;

    // global register offsets (region 0)
    localparam logic [7:0] A_TBASE   = 8'h04;
    localparam logic [7:0] A_ENA     = 8'h08;
    localparam logic [7:0] A_ENA_SET = 8'h0C;
    localparam logic [7:0] A_ENA_CLR = 8'h10;
    localparam logic [7:0] A_IEN     = 8'h14;
    localparam logic [7:0] A_IEN_SET = 8'h18;
    localparam logic [7:0] A_IEN_CLR = 8'h1C;
    localparam logic [7:0] A_TRIG    = 8'h20;
    localparam logic [7:0] A_BUSY    = 8'h24;
    localparam logic [7:0] A_DONE    = 8'h28;
    localparam logic [7:0] A_ERR     = 8'h2C;
    localparam logic [7:0] A_ABORT   = 8'h30;

    // per-channel register offsets (region 1, 16 bytes per channel)
    localparam logic [3:0] A_CH_CFG  = 4'h0;
    localparam logic [3:0] A_CH_XCFG = 4'h4;

    // width code 3 is treated as 32 bit
    function automatic logic [1:0] size_of(input logic [1:0] w);
        return (w == 2'd3) ? 2'd2 : w;
    endfunction

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  ready,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (ready[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_item_addr.sv
module dma_item_addr #(
    parameter int AW = 32,
    parameter int CW = 10
) (
    input  logic [AW-1:0] end_addr,
    input  logic [CW-1:0] rem,
    input  logic [1:0]    wid,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] back;
    always_comb begin
        unique case (dma_pkg::size_of(wid))
            2'd0:    back = AW'(rem);
            2'd1:    back = AW'(rem) << 1;
            default: back = AW'(rem) << 2;
        endcase
        addr = inc ? (end_addr - back) : end_addr;
    end
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 10,
    parameter int RAW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic [NCH-1:0] dreq,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ack,
    input  logic           mem_err,
    input  logic [DW-1:0]  mem_rdata,
    output logic           irq
);
    import dma_pkg::*;

    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int TBW = AW - 9;

    typedef struct packed {
        logic          valid;
        logic          seti;
        logic [1:0]    wid;
        logic          sinc;
        logic          dinc;
        logic [CW-1:0] cnt;
    } xcfg_t;

    typedef struct packed {
        dma_st_e                  st;
        logic [CIW-1:0]           cur;
        logic [DW-1:0]            data;
        logic [TBW-1:0]           tbase;
        logic [NCH-1:0]           ena;
        logic [NCH-1:0]           ien;
        logic [NCH-1:0]           busy;
        logic [NCH-1:0]           donef;
        logic [NCH-1:0]           errf;
        logic [NCH-1:0]           loaded;
        logic [NCH-1:0]           preq;
        xcfg_t [NCH-1:0]          xc;
        logic [NCH-1:0][AW-1:0]   send;
        logic [NCH-1:0][AW-1:0]   dend;
        logic [NCH-1:0][CW-1:0]   rem;
    } state_t;

    state_t q, d;

    logic [NCH-1:0] ready;
    logic           pick_any;
    logic [CIW-1:0] pick_idx;
    logic [AW-1:0]  src_addr, dst_addr;
    logic [1:0]     item_sz;
    logic [DW-1:0]  item_data;
    logic [NCH-1:0] busy_vec, errf_vec;

    assign busy_vec = q.busy;
    assign errf_vec = q.errf;

    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            ready[n] = q.busy[n] & q.ena[n] & q.xc[n].valid &
                       (~q.loaded[n] | ~q.preq[n] | dreq[n]);
        end
    end

    dma_prio_pick #(.N(NCH), .IW(CIW)) u_pick (
        .ready (ready),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    dma_item_addr #(.AW(AW), .CW(CW)) u_src_addr (
        .end_addr (q.send[q.cur]),
        .rem      (q.rem[q.cur]),
        .wid      (q.xc[q.cur].wid),
        .inc      (q.xc[q.cur].sinc),
        .addr     (src_addr)
    );

    dma_item_addr #(.AW(AW), .CW(CW)) u_dst_addr (
        .end_addr (q.dend[q.cur]),
        .rem      (q.rem[q.cur]),
        .wid      (q.xc[q.cur].wid),
        .inc      (q.xc[q.cur].dinc),
        .addr     (dst_addr)
    );

    assign item_sz = size_of(q.xc[q.cur].wid);

    always_comb begin
        unique case (item_sz)
            2'd0:    item_data = mem_rdata & DW'(32'h0000_00FF);
            2'd1:    item_data = mem_rdata & DW'(32'h0000_FFFF);
            default: item_data = mem_rdata;
        endcase
    end

    // memory master outputs
    always_comb begin
        mem_req   = (q.st != S_IDLE);
        mem_we    = (q.st == S_WR);
        mem_wdata = q.data;
        mem_size  = item_sz;
        unique case (q.st)
            S_FSRC: begin
                mem_addr = {q.tbase, 9'b0} + AW'({q.cur, 4'h0}) + AW'(4);
                mem_size = 2'd2;
            end
            S_FDST: begin
                mem_addr = {q.tbase, 9'b0} + AW'({q.cur, 4'h0}) + AW'(8);
                mem_size = 2'd2;
            end
            S_RD:    mem_addr = src_addr;
            S_WR:    mem_addr = dst_addr;
            default: mem_addr = '0;
        endcase
    end

    assign irq = |((q.donef | q.errf) & q.ien);

    // register read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr[RAW-1:8] == '0) begin
            unique case (reg_addr[7:0])
                A_TBASE: reg_rdata = DW'({q.tbase, 9'b0});
                A_ENA:   reg_rdata = DW'(q.ena);
                A_IEN:   reg_rdata = DW'(q.ien);
                A_BUSY:  reg_rdata = DW'(q.busy);
                A_DONE:  reg_rdata = DW'(q.donef);
                A_ERR:   reg_rdata = DW'(q.errf);
                default: reg_rdata = '0;
            endcase
        end else if (reg_addr[RAW-1:8] == (RAW-8)'(1)) begin
            for (int n = 0; n < NCH; n++) begin
                if (reg_addr[7:4] == 4'(n)) begin
                    if (reg_addr[3:0] == A_CH_CFG)
                        reg_rdata = DW'(q.preq[n]);
                    else if (reg_addr[3:0] == A_CH_XCFG)
                        reg_rdata = DW'({q.xc[n].cnt, 10'b0, q.xc[n].dinc, q.xc[n].sinc,
                                         q.xc[n].wid, q.xc[n].seti, q.xc[n].valid});
                end
            end
        end
    end

    // next-state logic
    always_comb begin
        logic           gw, cw;
        logic [NCH-1:0] wb;
        logic           live;

        d    = q;
        gw   = reg_we && (reg_addr[RAW-1:8] == '0);
        cw   = reg_we && (reg_addr[RAW-1:8] == (RAW-8)'(1));
        wb   = reg_wdata[NCH-1:0];
        live = q.busy[q.cur];

        // write-1-to-clear flags first so that a same-cycle set wins
        if (gw && reg_addr[7:0] == A_DONE) d.donef = q.donef & ~wb;
        if (gw && reg_addr[7:0] == A_ERR)  d.errf  = q.errf & ~wb;

        unique case (q.st)
            S_IDLE: begin
                if (pick_any) begin
                    d.cur = pick_idx;
                    d.st  = q.loaded[pick_idx] ? S_RD : S_FSRC;
                end
            end
            default: begin
                if (mem_ack) begin
                    d.st = S_IDLE;
                    if (live && mem_err) begin
                        d.errf[q.cur]   = 1'b1;
                        d.busy[q.cur]   = 1'b0;
                        d.loaded[q.cur] = 1'b0;
                    end else if (live) begin
                        unique case (q.st)
                            S_FSRC: begin
                                d.send[q.cur] = AW'(mem_rdata);
                                d.st          = S_FDST;
                            end
                            S_FDST: begin
                                d.dend[q.cur]   = AW'(mem_rdata);
                                d.rem[q.cur]    = q.xc[q.cur].cnt;
                                d.loaded[q.cur] = 1'b1;
                            end
                            S_RD: begin
                                d.data = item_data;
                                d.st   = S_WR;
                            end
                            default: begin
                                if (q.rem[q.cur] == '0) begin
                                    d.busy[q.cur]   = 1'b0;
                                    d.loaded[q.cur] = 1'b0;
                                    if (q.xc[q.cur].seti) d.donef[q.cur] = 1'b1;
                                end else begin
                                    d.rem[q.cur] = q.rem[q.cur] - 1'b1;
                                end
                            end
                        endcase
                    end
                end
            end
        endcase

        if (gw) begin
            unique case (reg_addr[7:0])
                A_TBASE:   d.tbase = reg_wdata[AW-1:9];
                A_ENA_SET: d.ena   = q.ena | wb;
                A_ENA_CLR: d.ena   = q.ena & ~wb;
                A_IEN_SET: d.ien   = q.ien | wb;
                A_IEN_CLR: d.ien   = q.ien & ~wb;
                default: ;
            endcase
        end

        for (int n = 0; n < NCH; n++) begin
            if (cw && reg_addr[7:4] == 4'(n)) begin
                if (reg_addr[3:0] == A_CH_CFG) d.preq[n] = reg_wdata[0];
                if (reg_addr[3:0] == A_CH_XCFG) begin
                    d.xc[n].valid = reg_wdata[0];
                    d.xc[n].seti  = reg_wdata[1];
                    d.xc[n].wid   = reg_wdata[3:2];
                    d.xc[n].sinc  = reg_wdata[4];
                    d.xc[n].dinc  = reg_wdata[5];
                    d.xc[n].cnt   = reg_wdata[16+CW-1:16];
                end
            end
        end

        if (gw && reg_addr[7:0] == A_ABORT) begin
            d.busy   = d.busy & ~wb;
            d.loaded = d.loaded & ~wb;
        end

        if (gw && reg_addr[7:0] == A_TRIG) begin
            for (int n = 0; n < NCH; n++) begin
                if (wb[n] && !d.busy[n] && d.ena[n] && d.xc[n].valid) begin
                    d.busy[n]   = 1'b1;
                    d.loaded[n] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int RAW = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_we,
    input logic [RAW-1:0] reg_addr,
    input logic [DW-1:0]  reg_wdata,
    input logic           mem_req,
    input logic           mem_ack,
    input logic           mem_err,
    input logic [AW-1:0]  mem_addr,
    input logic           irq,
    input logic [NCH-1:0] busy,
    input logic [NCH-1:0] errf
);
    import dma_pkg::*;

    logic abort_wr;
    assign abort_wr = reg_we && (reg_addr[RAW-1:8] == '0) && (reg_addr[7:0] == A_ABORT);

    // R5: an access is held with a steady address until acknowledged
    p_req_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R6: a new access only begins while some channel is busy
    p_req_needs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> ($past(busy) != '0));

    // R9: an aborted channel is not busy on the next cycle
    p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_wr |=> ((busy & $past(reg_wdata[NCH-1:0])) == '0));

    // R11: an error response raises a new error flag unless software intervened
    p_err_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (((errf & ~$past(errf)) != '0) || $past(reg_we)));

    // R8: busy bits only drop after a memory acknowledge or a register write
    p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(busy) & ~busy) != '0) |-> ($past(mem_ack) || $past(reg_we)));

    // R12: the interrupt rises only after a memory acknowledge or a register write
    p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(mem_ack) || $past(reg_we)));

endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH), .AW(AW), .DW(DW), .RAW(RAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_addr  (mem_addr),
    .irq       (irq),
    .busy      (busy_vec),
    .errf      (errf_vec)
);

// File: tb/tb_dma_engine.sv
`timescale 1ns/1ps
module tb_dma_engine;
    import dma_pkg::*;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  dreq = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ack, mem_err;
    logic [31:0] mem_rdata;
    logic        irq;

    always #10 clk = ~clk;

    dma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    typedef struct {
        logic [11:0] a;
        logic [1:0]  sz;
        logic [31:0] d;
    } exp_t;

    exp_t        sb[$];
    logic [7:0]  mem [0:4095];
    int          n_chk = 0;
    int          n_err = 0;
    int          n_wr = 0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic        done = 1'b0;

    function automatic logic [31:0] mrd(input logic [11:0] a, input logic [1:0] sz);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < (1 << sz); i++) v[8*i +: 8] = mem[12'(a + 12'(i))];
        return v;
    endfunction

    // memory model and scoreboard monitor
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_err   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (err_en && mem_addr == err_addr) begin
                    mem_err <= 1'b1;
                end else if (mem_we) begin
                    exp_t e;
                    n_wr++;
                    for (int i = 0; i < (1 << mem_size); i++)
                        mem[12'(mem_addr[11:0] + 12'(i))] = mem_wdata[8*i +: 8];
                    n_chk++;
                    if (sb.size() == 0) begin
                        n_err++;
                        $display("FAIL R5: unexpected write actual=%h@%h expected=none",
                                 mem_wdata, mem_addr);
                    end else begin
                        e = sb.pop_front();
                        if (mem_addr[11:0] !== e.a || mem_size !== e.sz || mem_wdata !== e.d) begin
                            n_err++;
                            $display("FAIL R5: write actual=%h@%h sz%0d expected=%h@%h sz%0d",
                                     mem_wdata, mem_addr, mem_size, e.d, e.a, e.sz);
                        end
                    end
                end else begin
                    mem_rdata <= mrd(mem_addr[11:0], mem_size);
                end
            end
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [11:0] cha(input int ch, input logic [3:0] off);
        return 12'h100 + 12'(16 * ch) + 12'(off);
    endfunction

    // driver: program a channel, write its descriptor, push expected writes
    task automatic setup(input int ch, input logic [11:0] s0, input logic [11:0] d0,
                         input logic [1:0] wid, input bit si, input bit di, input int n,
                         input bit pq, input bit seti, input bit push);
        int w;
        logic [31:0] se, de;
        w  = 1 << wid;
        se = si ? 32'(s0) + 32'((n - 1) * w) : 32'(s0);
        de = di ? 32'(d0) + 32'((n - 1) * w) : 32'(d0);
        for (int i = 0; i < 4; i++) begin
            mem[12'h200 + 12'(16 * ch) + 12'(4 + i)] = se[8*i +: 8];
            mem[12'h200 + 12'(16 * ch) + 12'(8 + i)] = de[8*i +: 8];
        end
        wr(cha(ch, A_CH_CFG), 32'(pq));
        wr(cha(ch, A_CH_XCFG), 32'(1) | (32'(seti) << 1) | (32'(wid) << 2) |
                               (32'(si) << 4) | (32'(di) << 5) | (32'(n - 1) << 16));
        if (push) begin
            for (int i = 0; i < n; i++) begin
                exp_t e;
                e.a  = di ? d0 + 12'(i * w) : d0;
                e.sz = wid;
                e.d  = mrd(si ? s0 + 12'(i * w) : s0, wid);
                sb.push_back(e);
            end
        end
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd({4'h0, A_BUSY}, v);
            if (v == 0) break;
        end
    endtask

    task automatic pulse_req(input int ch);
        @(negedge clk) dreq[ch] = 1'b1;
        @(negedge clk) dreq[ch] = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int w0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd({4'h0, A_ENA}, v);  chk("R1 ena", v, 0);
        rd({4'h0, A_IEN}, v);  chk("R1 ien", v, 0);
        rd({4'h0, A_BUSY}, v); chk("R1 busy", v, 0);
        rd({4'h0, A_DONE}, v); chk("R1 done", v, 0);
        rd({4'h0, A_ERR}, v);  chk("R1 err", v, 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 irq", 32'(irq), 0);

        // R3 base keeps bits 31:9
        wr({4'h0, A_TBASE}, 32'h0000_0234);
        rd({4'h0, A_TBASE}, v); chk("R3 tbase", v, 32'h0000_0200);

        // R2 set/clear bitmaps
        wr({4'h0, A_ENA_SET}, 32'h5); rd({4'h0, A_ENA}, v); chk("R2 ena set", v, 32'h5);
        wr({4'h0, A_ENA_CLR}, 32'h1); rd({4'h0, A_ENA}, v); chk("R2 ena clr", v, 32'h4);
        wr({4'h0, A_ENA_SET}, 32'h0); rd({4'h0, A_ENA}, v); chk("R2 ena zero", v, 32'h4);
        wr({4'h0, A_IEN_SET}, 32'hA); wr({4'h0, A_IEN_CLR}, 32'h8);
        rd({4'h0, A_IEN}, v); chk("R2 ien", v, 32'h2);
        wr({4'h0, A_IEN_CLR}, 32'hF);
        wr({4'h0, A_ENA_CLR}, 32'hF);

        // R6 trigger ignored when not enabled or not valid
        setup(1, 12'h400, 12'h600, 2'd2, 1, 1, 2, 0, 0, 0);
        w0 = n_wr;
        wr({4'h0, A_TRIG}, 32'h2);
        rd({4'h0, A_BUSY}, v); chk("R6 not enabled", v, 0);
        wr(cha(1, A_CH_XCFG), 32'h0);
        wr({4'h0, A_ENA_SET}, 32'h2);
        wr({4'h0, A_TRIG}, 32'h2);
        rd({4'h0, A_BUSY}, v); chk("R6 not valid", v, 0);
        repeat (20) @(negedge clk);
        chk("R6 no writes", 32'(n_wr - w0), 0);
        wr({4'h0, A_ENA_CLR}, 32'h2);

        // R4 R5 R8 32-bit copy of four items on channel 0
        wr({4'h0, A_ENA_SET}, 32'h1);
        setup(0, 12'h400, 12'h600, 2'd2, 1, 1, 4, 0, 1, 1);
        wr({4'h0, A_TRIG}, 32'h1);
        rd({4'h0, A_BUSY}, v); chk("R8 busy during", v, 32'h1);
        wait_idle();
        chk("R4 all items moved", 32'(sb.size()), 0);
        rd({4'h0, A_DONE}, v); chk("R8 done flag", v, 32'h1);
        chk("R12 irq masked", 32'(irq), 0);
        wr({4'h0, A_IEN_SET}, 32'h1);
        @(negedge clk); #1 chk("R12 irq on", 32'(irq), 1);
        wr({4'h0, A_DONE}, 32'h1);
        rd({4'h0, A_DONE}, v); chk("R8 done w1c", v, 0);
        chk("R12 irq off", 32'(irq), 0);
        wr({4'h0, A_IEN_CLR}, 32'h1);

        // R4 count 0 moves one 16-bit item
        w0 = n_wr;
        setup(0, 12'h412, 12'h640, 2'd1, 1, 1, 1, 0, 0, 1);
        wr({4'h0, A_TRIG}, 32'h1);
        wait_idle();
        chk("R4 single item", 32'(n_wr - w0), 1);

        // R5 fixed byte source, incrementing destination
        setup(0, 12'h500, 12'h650, 2'd0, 0, 1, 3, 0, 0, 1);
        wr({4'h0, A_TRIG}, 32'h1);
        wait_idle();
        chk("R5 fixed src drained", 32'(sb.size()), 0);

        // R5 incrementing halfword source, fixed destination
        setup(0, 12'h420, 12'h660, 2'd1, 1, 0, 3, 0, 0, 1);
        wr({4'h0, A_TRIG}, 32'h1);
        wait_idle();
        chk("R5 fixed dst drained", 32'(sb.size()), 0);

        // R10 priority: channel 0 finishes before channel 1
        wr({4'h0, A_ENA_SET}, 32'h3);
        setup(0, 12'h430, 12'h680, 2'd2, 1, 1, 2, 0, 0, 1);
        setup(1, 12'h440, 12'h6A0, 2'd2, 1, 1, 2, 0, 0, 1);
        wr({4'h0, A_TRIG}, 32'h3);
        wait_idle();
        chk("R10 order drained", 32'(sb.size()), 0);

        // R7 request pacing on channel 2
        wr({4'h0, A_ENA_SET}, 32'h4);
        setup(2, 12'h450, 12'h6C0, 2'd2, 1, 1, 3, 1, 0, 1);
        w0 = n_wr;
        wr({4'h0, A_TRIG}, 32'h4);
        repeat (30) @(negedge clk);
        chk("R7 held without dreq", 32'(n_wr - w0), 0);
        rd({4'h0, A_BUSY}, v); chk("R7 busy waiting", v, 32'h4);
        for (int k = 0; k < 3; k++) begin
            pulse_req(2);
            chk("R7 one item per pulse", 32'(n_wr - w0), 32'(k + 1));
        end
        rd({4'h0, A_BUSY}, v); chk("R7 busy end", v, 0);

        // R9 abort a waiting channel
        wr({4'h0, A_ENA_SET}, 32'h8);
        setup(3, 12'h460, 12'h6D0, 2'd2, 1, 1, 5, 1, 1, 0);
        wr({4'h0, A_TRIG}, 32'h8);
        repeat (30) @(negedge clk);
        rd({4'h0, A_BUSY}, v); chk("R9 busy before", v, 32'h8);
        wr({4'h0, A_ABORT}, 32'h8);
        rd({4'h0, A_BUSY}, v); chk("R9 busy cleared", v, 0);
        w0 = n_wr;
        pulse_req(3);
        chk("R9 nothing moves", 32'(n_wr - w0), 0);
        rd({4'h0, A_DONE}, v); chk("R9 no done", v, 0);

        // R11 R12 bus error on channel 1 source read
        err_en = 1'b1; err_addr = 32'h480;
        wr({4'h0, A_IEN_SET}, 32'h2);
        setup(1, 12'h480, 12'h6E0, 2'd2, 1, 1, 2, 0, 1, 0);
        w0 = n_wr;
        wr({4'h0, A_TRIG}, 32'h2);
        wait_idle();
        rd({4'h0, A_ERR}, v); chk("R11 err flag", v, 32'h2);
        chk("R11 no write", 32'(n_wr - w0), 0);
        rd({4'h0, A_DONE}, v); chk("R11 no done", v, 0);
        chk("R12 irq on error", 32'(irq), 1);
        wr({4'h0, A_ERR}, 32'h2);
        rd({4'h0, A_ERR}, v); chk("R11 err w1c", v, 0);
        chk("R12 irq cleared", 32'(irq), 0);
        err_en = 1'b0;

        chk("R5 scoreboard empty", 32'(sb.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule